// File: doc/BRIEF.md
# Audio Sample Format Converter

This block sits on the path between one audio client and a routing fabric and reshapes a stream of samples from one format into another. Each side, client and hub, has its own channel count and sample width. A single 32-bit control word sets both formats and the conversion options, and a direction bit decides which side is the source. Samples travel one word at a time over valid/ready handshakes. Each word is MSB-aligned in a 32-bit container and comes with a marker that flags the first channel of a frame.

Three jobs are done per sample. Widening pads the new low-order bits with zeros, ones or bits from a pseudo-random register. Narrowing either chops the discarded bits or rounds to nearest with saturation. A two-channel source can be folded into one channel, and a one-channel source can be spread over several output channels. The control word is sampled only when an accepted input carries the first-channel marker, so a frame is never converted under two formats.

A small sequencer runs the flow. Its states are:

- ST_TAKE: waits for an input sample.
- ST_PAIR: holds the first sample of a stereo pair and waits for the second.
- ST_SEND: presents the converted sample.
- ST_EXTRA: presents the added channels of an expansion.

Its transitions are:

- TAKE→PAIR: the first half of a fold is accepted.
- TAKE→SEND: any other sample is accepted.
- PAIR→SEND: the second half of a fold is accepted.
- SEND→EXTRA: the output is taken and added channels remain.
- SEND→TAKE: the output is taken and no added channels remain.
- EXTRA→TAKE: the last added channel is taken.

Top module: `audio_fmt_conv`

## Requirements
- R1: Width codes are 3 bits wide, and code n means 4*(n+1) bits. The hub width code is in bits 14:12 and the client width code is in bits 10:8. When the destination is wider, the added bits are filled according to bits 7:6: 0 fills with zeros and 1 fills with ones. Bits below the destination width are 0.
- R2: Fill code 2 takes the added bits from a 16-bit register that is repeated across the word. The register is a Fibonacci shifter with taps 16, 14, 13 and 11, so the new bit 0 is q[15]^q[13]^q[12]^q[10]. It resets to 0xACE1 and steps once for each widened sample that uses this fill.
- R3: When the destination is narrower and bit 1 is 1, the sample is cut to the destination width with no rounding.
- R4: When the destination is narrower and bit 1 is 0, half a destination LSB is added before cutting. A positive sample that would wrap saturates to the largest positive value instead.
- R5: A source of 2 channels with a destination of 1 channel is a fold. Bits 5:4 pick the result: 0 gives channel 0, 1 gives channel 1, and 2 gives the average. The average is the arithmetic right shift of the sign-extended sum of both channels, cut to the source width. Every fold output carries the first-channel marker.
- R6: A source of 1 channel with a destination of N > 1 channels is an expansion. Each input gives N outputs, and only the first output carries the marker. The added channels copy the converted sample when bit 0 or bit 3 is set, and are zero otherwise.
- R7: Channel counts are stored minus one: the hub count is in bits 26:24 and the client count is in bits 18:16. With bit 2 = 0 the client fields describe the source and the hub fields the destination. With bit 2 = 1 the roles are swapped.
- R8: The control word is taken only when an accepted input has in_first = 1, and it applies from that sample onward. A change to ctrl_word with no marker has no effect.
- R9: The threshold field, bits 31:28, has no effect on the output data.
- R10: After reset out_valid = 0 and in_ready = 1. While out_valid = 1 and out_ready = 0, out_data and out_first stay fixed and in_ready stays 0.
- R11: When the source and destination channel counts are equal, samples pass one for one and keep their in_first value. Bits below the source width are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_word | input | 32 | Format and conversion control word |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can accept an input sample |
| in_data | input | 32 | Input sample, MSB-aligned |
| in_first | input | 1 | Input sample is channel 0 of a frame |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream accepts the output sample |
| out_data | output | 32 | Output sample, MSB-aligned |
| out_first | output | 1 | Output sample is channel 0 of a frame |

## Verification
A converted sample appears on the output in the cycle after the clock edge that accepts its input. For a fold, that edge is the one that accepts the second sample of the pair. The added channels of an expansion follow, one per cycle, each after the edge that takes the previous output. The bench drives each input on a falling edge and waits for in_ready. It then reads the output on the next falling edge, so each read comes a full half period after the register that produced the value has updated. The output is released only after it has been checked. Stall checks hold out_ready low over several falling edges and compare the output at each one.

// File: rtl/afc_pkg.sv
package afc_pkg;

    localparam int unsigned SAMPLE_W = 32;
    localparam int unsigned CTRL_W   = 32;
    localparam int unsigned CODE_W   = 3;
    localparam int unsigned CNT_W    = 3;
    localparam int unsigned LFSR_W   = 16;
    localparam int unsigned STEP_W   = SAMPLE_W / 8;

    // control word field positions
    localparam int unsigned POS_HUB_CNT  = 24;
    localparam int unsigned POS_CLI_CNT  = 16;
    localparam int unsigned POS_HUB_CODE = 12;
    localparam int unsigned POS_CLI_CODE = 8;
    localparam int unsigned POS_FILL     = 6;
    localparam int unsigned POS_FOLD     = 4;
    localparam int unsigned POS_REPL     = 3;
    localparam int unsigned POS_DIR      = 2;
    localparam int unsigned POS_CHOP     = 1;
    localparam int unsigned POS_MONO     = 0;

    typedef enum logic [1:0] {
        FILL_ZERO = 2'd0,
        FILL_ONE  = 2'd1,
        FILL_RAND = 2'd2,
        FILL_RSVD = 2'd3
    } fill_e;

    typedef enum logic [1:0] {
        FOLD_CH0  = 2'd0,
        FOLD_CH1  = 2'd1,
        FOLD_AVG  = 2'd2,
        FOLD_RSVD = 2'd3
    } fold_e;

    typedef enum logic [1:0] {
        ST_TAKE  = 2'd0,
        ST_PAIR  = 2'd1,
        ST_SEND  = 2'd2,
        ST_EXTRA = 2'd3
    } afc_state_e;

    typedef struct packed {
        logic [CODE_W-1:0] src_code;
        logic [CODE_W-1:0] dst_code;
        logic [CNT_W-1:0]  src_cnt;
        logic [CNT_W-1:0]  dst_cnt;
        fill_e             fill;
        fold_e             fold;
        logic              chop;
        logic              mono_copy;
        logic              replicate;
    } fmt_t;

    function automatic logic [SAMPLE_W-1:0] keep_mask(input logic [CODE_W-1:0] code);
        int unsigned bits;
        bits = STEP_W * (int'(code) + 1);
        return ~({SAMPLE_W{1'b1}} >> bits);
    endfunction

    function automatic fmt_t decode_fmt(input logic [CTRL_W-1:0] w);
        fmt_t              f;
        logic [CODE_W-1:0] hub_code;
        logic [CODE_W-1:0] cli_code;
        logic [CNT_W-1:0]  hub_cnt;
        logic [CNT_W-1:0]  cli_cnt;
        hub_code = w[POS_HUB_CODE +: CODE_W];
        cli_code = w[POS_CLI_CODE +: CODE_W];
        hub_cnt  = w[POS_HUB_CNT  +: CNT_W];
        cli_cnt  = w[POS_CLI_CNT  +: CNT_W];
        if (w[POS_DIR]) begin
            f.src_code = hub_code;
            f.dst_code = cli_code;
            f.src_cnt  = hub_cnt;
            f.dst_cnt  = cli_cnt;
        end else begin
            f.src_code = cli_code;
            f.dst_code = hub_code;
            f.src_cnt  = cli_cnt;
            f.dst_cnt  = hub_cnt;
        end
        f.fill      = fill_e'(w[POS_FILL +: 2]);
        f.fold      = fold_e'(w[POS_FOLD +: 2]);
        f.chop      = w[POS_CHOP];
        f.mono_copy = w[POS_MONO];
        f.replicate = w[POS_REPL];
        return f;
    endfunction

endpackage

// File: rtl/afc_lfsr.sv
module afc_lfsr
    import afc_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SEED = 16'hACE1,
    parameter logic [LFSR_W-1:0] TAPS = 16'hB400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    output logic [LFSR_W-1:0] q
);

    logic fb;

    always_comb begin
        fb = ^(q & TAPS);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= SEED;
        end else if (adv) begin
            q <= {q[LFSR_W-2:0], fb};
        end
    end

    assert_lfsr_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        q != '0)
        else $error("noise register reached zero");

    assert_lfsr_steps_R2: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (q != $past(q)))
        else $error("noise register did not step");

    assert_lfsr_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(q))
        else $error("noise register stepped without request");

endmodule

// File: rtl/afc_fold.sv
module afc_fold
    import afc_pkg::*;
(
    input  logic [SAMPLE_W-1:0] ch0,
    input  logic [SAMPLE_W-1:0] ch1,
    input  fold_e               mode,
    output logic [SAMPLE_W-1:0] y
);

    logic [SAMPLE_W:0] total;

    always_comb begin
        total = {ch0[SAMPLE_W-1], ch0} + {ch1[SAMPLE_W-1], ch1};
        unique case (mode)
            FOLD_CH1: y = ch1;
            FOLD_AVG: y = total[SAMPLE_W:1];
            default:  y = ch0;
        endcase
    end

endmodule

// File: rtl/afc_resize.sv
module afc_resize
    import afc_pkg::*;
(
    input  logic [SAMPLE_W-1:0] sample,
    input  logic [CODE_W-1:0]   src_code,
    input  logic [CODE_W-1:0]   dst_code,
    input  fill_e               fill,
    input  logic                chop,
    input  logic [LFSR_W-1:0]   noise,
    output logic [SAMPLE_W-1:0] result,
    output logic                widened
);

    localparam int unsigned REP = SAMPLE_W / LFSR_W;
    localparam logic [SAMPLE_W-1:0] MAX_POS = {1'b0, {(SAMPLE_W-1){1'b1}}};

    logic [SAMPLE_W-1:0] keep_s;
    logic [SAMPLE_W-1:0] keep_d;
    logic [SAMPLE_W-1:0] src_v;
    logic [SAMPLE_W-1:0] low_d;
    logic [SAMPLE_W-1:0] half_lsb;
    logic [SAMPLE_W-1:0] rounded;
    logic [SAMPLE_W-1:0] pattern;
    logic                narrowed;
    logic                wrap;

    always_comb begin
        keep_s   = keep_mask(src_code);
        keep_d   = keep_mask(dst_code);
        src_v    = sample & keep_s;
        low_d    = ~keep_d;
        half_lsb = low_d & ~(low_d >> 1);
        rounded  = src_v + half_lsb;
        wrap     = !src_v[SAMPLE_W-1] && rounded[SAMPLE_W-1];
        widened  = dst_code > src_code;
        narrowed = dst_code < src_code;
        unique case (fill)
            FILL_ONE:  pattern = {SAMPLE_W{1'b1}};
            FILL_RAND: pattern = {REP{noise}};
            default:   pattern = '0;
        endcase
        if (widened) begin
            result = src_v | (pattern & keep_d & ~keep_s);
        end else if (narrowed && chop) begin
            result = src_v & keep_d;
        end else if (narrowed) begin
            result = wrap ? (MAX_POS & keep_d) : (rounded & keep_d);
        end else begin
            result = src_v;
        end
    end

    always_comb begin
        assert_below_lsb_clear_R1: assert ((result & ~keep_d) == '0)
            else $error("bits below destination width are set");
        if (narrowed && !chop && !src_v[SAMPLE_W-1]) begin
            assert_no_wrap_R4: assert (!result[SAMPLE_W-1])
                else $error("rounding wrapped a positive sample");
        end
    end

endmodule

// File: rtl/audio_fmt_conv.sv
module audio_fmt_conv
    import afc_pkg::*;
#(
    parameter logic [LFSR_W-1:0] NOISE_SEED = 16'hACE1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CTRL_W-1:0]   ctrl_word,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [SAMPLE_W-1:0] in_data,
    input  logic                in_first,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [SAMPLE_W-1:0] out_data,
    output logic                out_first
);

    afc_state_e          state_q;
    afc_state_e          state_d;
    logic [CTRL_W-1:0]   cfg_q;
    logic [CTRL_W-1:0]   cfg_eff;
    fmt_t                fmt;
    fmt_t                fmt_cur;
    logic                in_fire;
    logic                out_fire;
    logic                fold_mode;
    logic                expand_mode;
    logic                conv_fire;
    logic [SAMPLE_W-1:0] hold_q;
    logic [SAMPLE_W-1:0] second_m;
    logic [SAMPLE_W-1:0] fold_y;
    logic [SAMPLE_W-1:0] conv_in;
    logic [SAMPLE_W-1:0] conv_out;
    logic                widened;
    logic [LFSR_W-1:0]   noise;
    logic                noise_adv;
    logic [SAMPLE_W-1:0] main_q;
    logic                main_first_q;
    logic [SAMPLE_W-1:0] extra_q;
    logic [CNT_W-1:0]    extra_cnt_q;

    // ---------------------------------------------------------------
    // Format selection: a new word is used from the marked sample on
    // ---------------------------------------------------------------
    always_comb begin
        in_fire     = in_valid && in_ready;
        out_fire    = out_valid && out_ready;
        cfg_eff     = (in_fire && in_first) ? ctrl_word : cfg_q;
        fmt         = decode_fmt(cfg_eff);
        fmt_cur     = decode_fmt(cfg_q);
        fold_mode   = (fmt.src_cnt == CNT_W'(1)) && (fmt.dst_cnt == '0);
        expand_mode = (fmt.src_cnt == '0) && (fmt.dst_cnt != '0);
        second_m    = in_data & keep_mask(fmt.src_code);
        conv_in     = (state_q == ST_PAIR) ? fold_y : in_data;
        conv_fire   = in_fire && ((state_q == ST_PAIR) || !fold_mode);
        noise_adv   = conv_fire && widened && (fmt.fill == FILL_RAND);
    end

    afc_fold u_fold (
        .ch0  (hold_q),
        .ch1  (second_m),
        .mode (fmt.fold),
        .y    (fold_y)
    );

    afc_resize u_resize (
        .sample   (conv_in),
        .src_code (fmt.src_code),
        .dst_code (fmt.dst_code),
        .fill     (fmt.fill),
        .chop     (fmt.chop),
        .noise    (noise),
        .result   (conv_out),
        .widened  (widened)
    );

    afc_lfsr #(
        .SEED (NOISE_SEED)
    ) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (noise_adv),
        .q     (noise)
    );

    // ---------------------------------------------------------------
    // Sequencer: state register
    // ---------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_TAKE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------------------------------------------------------
    // Sequencer: next state
    // ---------------------------------------------------------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_TAKE: begin
                if (in_fire) begin
                    state_d = fold_mode ? ST_PAIR : ST_SEND;
                end
            end
            ST_PAIR: begin
                if (in_fire) begin
                    state_d = ST_SEND;
                end
            end
            ST_SEND: begin
                if (out_fire) begin
                    state_d = (extra_cnt_q != '0) ? ST_EXTRA : ST_TAKE;
                end
            end
            ST_EXTRA: begin
                if (out_fire && (extra_cnt_q == CNT_W'(1))) begin
                    state_d = ST_TAKE;
                end
            end
            default: state_d = ST_TAKE;
        endcase
    end

    // ---------------------------------------------------------------
    // Datapath registers
    // ---------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q        <= '0;
            hold_q       <= '0;
            main_q       <= '0;
            main_first_q <= 1'b0;
            extra_q      <= '0;
            extra_cnt_q  <= '0;
        end else begin
            if (in_fire && in_first) begin
                cfg_q <= ctrl_word;
            end
            if (in_fire && (state_q == ST_TAKE) && fold_mode) begin
                hold_q <= in_data & keep_mask(fmt.src_code);
            end
            if (conv_fire) begin
                main_q       <= conv_out;
                main_first_q <= (fold_mode || expand_mode) ? 1'b1 : in_first;
                extra_q      <= (fmt.mono_copy || fmt.replicate) ? conv_out : '0;
                extra_cnt_q  <= expand_mode ? fmt.dst_cnt : '0;
            end else if (out_fire && (state_q == ST_EXTRA)) begin
                extra_cnt_q <= extra_cnt_q - CNT_W'(1);
            end
        end
    end

    // ---------------------------------------------------------------
    // Outputs
    // ---------------------------------------------------------------
    always_comb begin
        in_ready  = (state_q == ST_TAKE) || (state_q == ST_PAIR);
        out_valid = (state_q == ST_SEND) || (state_q == ST_EXTRA);
        out_data  = (state_q == ST_EXTRA) ? extra_q : main_q;
        out_first = (state_q == ST_SEND) && main_first_q;
    end

    // ---------------------------------------------------------------
    // Checks
    // ---------------------------------------------------------------
    assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_first)))
        else $error("output changed while stalled");

    assert_cfg_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready && in_first) |=> $stable(cfg_q))
        else $error("format changed off a frame boundary");

    assert_fold_marked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_SEND) && (fmt_cur.src_cnt == CNT_W'(1)) && (fmt_cur.dst_cnt == '0))
            |-> out_first)
        else $error("fold output lacks frame marker");

    assert_extra_left_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXTRA) |-> (extra_cnt_q != '0))
        else $error("added-channel state with nothing left");

endmodule

// File: tb/sim_audio_fmt_conv.sv
module sim_audio_fmt_conv;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] ctrl_word;
    logic        in_valid;
    logic        in_ready;
    logic [31:0] in_data;
    logic        in_first;
    logic        out_valid;
    logic        out_ready;
    logic [31:0] out_data;
    logic        out_first;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;
    logic [15:0] noise_m = 16'hACE1;

    always #(CLK_PERIOD/2) clk = ~clk;

    audio_fmt_conv u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_word (ctrl_word),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .in_first  (in_first),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_first (out_first)
    );

    function automatic logic [31:0] mk(input int hub_cnt, input int cli_cnt,
                                       input int hub_code, input int cli_code,
                                       input int fill, input int fold, input int repl,
                                       input int dir, input int chop, input int mono,
                                       input int thr);
        logic [31:0] w;
        w = (32'(thr) << 28) | (32'(hub_cnt) << 24) | (32'(cli_cnt) << 16)
          | (32'(hub_code) << 12) | (32'(cli_code) << 8) | (32'(fill) << 6)
          | (32'(fold) << 4) | (32'(repl) << 3) | (32'(dir) << 2)
          | (32'(chop) << 1) | 32'(mono);
        return w;
    endfunction

    function automatic logic [15:0] noise_step(input logic [15:0] q);
        return {q[14:0], q[15] ^ q[13] ^ q[12] ^ q[10]};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic put(input logic [31:0] d, input logic f);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        in_first = f;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic get(input string tag, input logic [31:0] exp_d, input logic exp_f);
        int waited = 0;
        @(negedge clk);
        while (!out_valid && waited < 20) begin
            @(negedge clk);
            waited++;
        end
        chk({tag, " data"}, out_data, exp_d);
        chk({tag, " first"}, 32'(out_first), 32'(exp_f));
        out_ready = 1'b1;
        @(posedge clk);
        #1;
        out_ready = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R10 reset out_valid", 32'(out_valid), 32'd0);
        chk("R10 reset in_ready", 32'(in_ready), 32'd1);
    endtask

    task automatic t_pass();
        ctrl_word = mk(0, 0, 3, 3, 0, 0, 0, 0, 0, 0, 0);
        put(32'h1234_ABCD, 1'b1);
        get("R11 pass cut", 32'h1234_0000, 1'b1);
        put(32'hFFFF_FFFF, 1'b0);
        get("R11 pass marker kept", 32'hFFFF_0000, 1'b0);
    endtask

    task automatic t_widen_fixed();
        ctrl_word = mk(0, 0, 5, 3, 0, 0, 0, 0, 0, 0, 0);
        put(32'h8001_7777, 1'b1);
        get("R1 zero fill", 32'h8001_0000, 1'b1);
        ctrl_word = mk(0, 0, 5, 3, 1, 0, 0, 0, 0, 0, 0);
        put(32'h8001_7777, 1'b1);
        get("R1 one fill", 32'h8001_FF00, 1'b1);
    endtask

    task automatic t_widen_noise();
        ctrl_word = mk(0, 0, 7, 3, 2, 0, 0, 0, 0, 0, 0);
        put(32'h1234_0000, 1'b1);
        get("R2 noise fill first", {16'h1234, noise_m}, 1'b1);
        noise_m = noise_step(noise_m);
        put(32'hFFFF_0000, 1'b1);
        get("R2 noise fill stepped", {16'hFFFF, noise_m}, 1'b1);
        noise_m = noise_step(noise_m);
    endtask

    task automatic t_chop();
        ctrl_word = mk(0, 0, 2, 7, 0, 0, 0, 0, 1, 0, 0);
        put(32'h1238_9999, 1'b1);
        get("R3 chop", 32'h1230_0000, 1'b1);
    endtask

    task automatic t_round();
        ctrl_word = mk(0, 0, 2, 7, 0, 0, 0, 0, 0, 0, 0);
        put(32'h1238_9999, 1'b1);
        get("R4 round up", 32'h1240_0000, 1'b1);
        put(32'h7FF8_0000, 1'b1);
        get("R4 saturate", 32'h7FF0_0000, 1'b1);
        put(32'hFFF8_0000, 1'b1);
        get("R4 negative half", 32'h0000_0000, 1'b1);
    endtask

    task automatic t_fold();
        ctrl_word = mk(0, 1, 3, 3, 0, 0, 0, 0, 0, 0, 0);
        put(32'h1000_0000, 1'b1);
        put(32'h3000_0000, 1'b0);
        get("R5 fold ch0", 32'h1000_0000, 1'b1);
        ctrl_word = mk(0, 1, 3, 3, 0, 1, 0, 0, 0, 0, 0);
        put(32'h1000_0000, 1'b1);
        put(32'h3000_0000, 1'b0);
        get("R5 fold ch1", 32'h3000_0000, 1'b1);
        ctrl_word = mk(0, 1, 3, 3, 0, 2, 0, 0, 0, 0, 0);
        put(32'h1000_0000, 1'b1);
        put(32'h3000_0000, 1'b0);
        get("R5 fold avg", 32'h2000_0000, 1'b1);
        put(32'h8000_0000, 1'b1);
        put(32'h8000_0000, 1'b0);
        get("R5 fold avg most negative", 32'h8000_0000, 1'b1);
        put(32'h0001_0000, 1'b1);
        put(32'h0002_0000, 1'b0);
        get("R5 fold avg odd cut", 32'h0001_0000, 1'b1);
        put(32'hFFFF_0000, 1'b1);
        put(32'h0001_0000, 1'b0);
        get("R5 fold avg mixed sign", 32'h0000_0000, 1'b1);
    endtask

    task automatic t_expand();
        ctrl_word = mk(1, 0, 3, 3, 0, 0, 0, 0, 0, 0, 0);
        put(32'hABCD_1111, 1'b1);
        get("R6 expand ch0", 32'hABCD_0000, 1'b1);
        get("R6 expand zero ch1", 32'h0000_0000, 1'b0);
        ctrl_word = mk(1, 0, 3, 3, 0, 0, 0, 0, 0, 1, 0);
        put(32'hABCD_1111, 1'b1);
        get("R6 copy ch0", 32'hABCD_0000, 1'b1);
        get("R6 copy ch1", 32'hABCD_0000, 1'b0);
        ctrl_word = mk(3, 0, 3, 3, 0, 0, 1, 0, 0, 0, 0);
        put(32'h5555_0000, 1'b1);
        get("R6 replicate ch0", 32'h5555_0000, 1'b1);
        for (int k = 1; k < 4; k++) get("R6 replicate added", 32'h5555_0000, 1'b0);
        ctrl_word = mk(2, 0, 3, 3, 0, 0, 0, 0, 0, 0, 0);
        put(32'h5555_0000, 1'b1);
        get("R6 three ch0", 32'h5555_0000, 1'b1);
        get("R6 three ch1", 32'h0000_0000, 1'b0);
        get("R6 three ch2", 32'h0000_0000, 1'b0);
        @(negedge clk);
        chk("R6 no fourth output", 32'(out_valid), 32'd0);
    endtask

    task automatic t_direction();
        ctrl_word = mk(0, 0, 3, 5, 0, 0, 0, 0, 1, 0, 0);
        put(32'h8001_7777, 1'b1);
        get("R7 client to hub", 32'h8001_0000, 1'b1);
        ctrl_word = mk(0, 0, 3, 5, 1, 0, 0, 1, 1, 0, 0);
        put(32'h8001_7777, 1'b1);
        get("R7 hub to client", 32'h8001_FF00, 1'b1);
    endtask

    task automatic t_frame_latch();
        ctrl_word = mk(0, 0, 3, 3, 0, 0, 0, 0, 0, 0, 0);
        put(32'h1234_5678, 1'b1);
        get("R8 base", 32'h1234_0000, 1'b1);
        ctrl_word = mk(0, 0, 0, 3, 0, 0, 0, 0, 1, 0, 0);
        put(32'h1234_5678, 1'b0);
        get("R8 unmarked keeps old", 32'h1234_0000, 1'b0);
        put(32'h1234_5678, 1'b1);
        get("R8 marked takes new", 32'h1000_0000, 1'b1);
    endtask

    task automatic t_threshold();
        ctrl_word = mk(0, 0, 3, 3, 0, 0, 0, 0, 0, 0, 15);
        put(32'h1234_5678, 1'b1);
        get("R9 threshold ignored", 32'h1234_0000, 1'b1);
    endtask

    task automatic t_stall();
        ctrl_word = mk(0, 0, 3, 3, 0, 0, 0, 0, 0, 0, 0);
        put(32'hCAFE_BEEF, 1'b1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R10 stall valid", 32'(out_valid), 32'd1);
            chk("R10 stall data", out_data, 32'hCAFE_0000);
            chk("R10 stall in_ready", 32'(in_ready), 32'd0);
        end
        get("R10 release", 32'hCAFE_0000, 1'b1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        rst_n     = 1'b0;
        ctrl_word = '0;
        in_valid  = 1'b0;
        in_data   = '0;
        in_first  = 1'b0;
        out_ready = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_pass();
        t_widen_fixed();
        t_widen_noise();
        t_chop();
        t_round();
        t_fold();
        t_expand();
        t_direction();
        t_frame_latch();
        t_threshold();
        t_stall();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule